// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block takes a 32-bit IEEE 754 single-precision word and turns it into a signed 32-bit two's-complement integer. The caller selects one of four rounding directions with a 2-bit code. Before any arithmetic, the input is sorted into one of five classes: zero, subnormal, normal, infinite or not-a-number. Only normal values go through the alignment shifter. The other classes take fixed paths that set the result and flags directly.

The caller presents a word, a mode and a valid strobe in the same cycle. One clock later the integer appears, registered, together with its own valid strobe and three flags: invalid (not-a-number input), overflow (result does not fit and was clamped) and inexact (fraction bits were thrown away). Rounding works from the integer part, a guard bit (the first discarded bit, weight one half) and a sticky bit (the OR of every discarded bit below the guard).

Top module: `f2i_convert`

## Requirements
- R1: The input word is split into sign (bit 31), exponent field (bits 30:23) and fraction field (bits 22:0). An exponent field of 255 with a zero fraction is infinity. An exponent field of 255 with a nonzero fraction is NaN. An exponent field of 0 with a nonzero fraction is subnormal, with no hidden leading one. An exponent field of 0 with a zero fraction is signed zero. All other exponent values are normal.
- R2: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high, and low otherwise. A synchronous active-high reset clears `out_valid` and the registered result. While `in_valid` is low, the result and flags hold their previous values.
- R3: The mode code selects the rounding direction: 0 = nearest with ties to even (the default), 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.
- R4: In mode 0, a value exactly halfway between two integers goes to the even one: 2.5 gives 2, 3.5 gives 4, -2.5 gives -2, 0.5 gives 0. Other values go to the nearest integer: 1.5 gives 2, 0.75 gives 1.
- R5: Mode 2 rounds up: 2.25 gives 3, -2.25 gives -2, -0.75 gives 0. Mode 3 rounds down: 1.75 gives 1, -1.75 gives -2, -0.75 gives -1. Mode 1 drops the fraction: -1.75 gives -1, 3.5 gives 3.
- R6: For a finite, in-range result, `out_inexact` is 1 exactly when at least one discarded fraction bit was 1. At most one of the three flags is ever high.
- R7: A NaN input (of either sign) gives 0x80000000 with `out_invalid` = 1 and the other two flags 0.
- R8: An infinite input gives 0x7FFFFFFF for plus infinity and 0x80000000 for minus infinity, with `out_overflow` = 1.
- R9: A finite result outside the range -2^31..2^31-1 is clamped to 0x7FFFFFFF (positive) or 0x80000000 (negative), with `out_overflow` = 1. Exactly -2^31 converts to 0x80000000 with no flag.
- R10: A subnormal input gives 0 in modes 0 and 1. In mode 2 it gives 1 if positive and 0 if negative. In mode 3 it gives -1 if negative and 0 if positive. `out_inexact` is always 1.
- R11: Plus zero and minus zero both give 0 with all flags clear, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and mode are valid this cycle |
| in_word | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction code |
| out_valid | output | 1 | Registered result is new this cycle |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | Input was NaN |
| out_overflow | output | 1 | Result was clamped to the integer range |
| out_inexact | output | 1 | Fraction bits were discarded |

## Verification
The hardest case to reach from the ports is where the guard and sticky bits split: an exact half with nothing below it, set against a half with a set bit below it. Most random floats never land on an exact tie. The vector table therefore uses hand-built words whose fraction ends precisely at the half position, and pairs them with 0.75 and 1.5, so both the even and odd integer neighbours are hit. The magnitudes at the edge of the integer range (-2^31 exactly, 2^31, and 2^31-128) are also driven directly, because they decide between clamping and a clean result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_NAN  = 3'd4
  } fclass_e;

  // Decide whether the truncated magnitude must be bumped by one.
  function automatic logic rnd_inc(rmode_e m, logic neg, logic lsb, logic g, logic st);
    logic any;
    any = g | st;
    case (m)
      RM_NEAR_EVEN: return g & (st | lsb);
      RM_TO_ZERO:   return 1'b0;
      RM_UP:        return ~neg & any;
      default:      return neg & any;
    endcase
  endfunction

  // Classify from the raw exponent and fraction fields.
  function automatic fclass_e classify_f(logic [EXP_W-1:0] e, logic [MAN_W-1:0] f);
    logic e_all1, e_all0, f_zero;
    e_all1 = &e;
    e_all0 = ~|e;
    f_zero = ~|f;
    if (e_all1) return f_zero ? CL_INF : CL_NAN;
    if (e_all0) return f_zero ? CL_ZERO : CL_SUB;
    return CL_NORM;
  endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0]   word,
  output logic             sign,
  output logic [EW-1:0]    exp_fld,
  output logic [MW:0]      sig,
  output fclass_e          fclass
);
  logic [MW-1:0] frac;

  assign sign    = word[EW+MW];
  assign exp_fld = word[EW+MW-1:MW];
  assign frac    = word[MW-1:0];
  assign fclass  = classify_f(exp_fld, frac);
  // Hidden one present only for normal numbers.
  assign sig     = {(fclass == CL_NORM), frac};
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int EW     = EXP_W,
  parameter int MW     = MAN_W,
  parameter int BIAS_V = BIAS,
  parameter int INT_W  = 32,
  parameter int FRAC_W = 32
) (
  input  fclass_e          fclass,
  input  logic [EW-1:0]    exp_fld,
  input  logic [MW:0]      sig,
  output logic [INT_W-1:0] int_part,
  output logic             guard,
  output logic             sticky,
  output logic             huge
);
  localparam int FIX_W = INT_W + FRAC_W;
  localparam int SH_W  = $clog2(FIX_W);
  localparam int UE_W  = EW + 2;
  localparam int OFS   = FRAC_W - MW;

  logic signed [UE_W-1:0] e_unb;
  logic signed [UE_W-1:0] sh_s;
  logic [SH_W-1:0]        sh_amt;
  logic [FIX_W-1:0]       fixed;
  logic                   tiny;

  assign e_unb  = $signed({2'b00, exp_fld}) - UE_W'(BIAS_V);
  assign sh_s   = e_unb + UE_W'(OFS);
  assign sh_amt = sh_s[SH_W-1:0];

  always_comb begin
    huge  = 1'b0;
    tiny  = 1'b0;
    fixed = '0;
    case (fclass)
      CL_SUB: tiny = 1'b1;
      CL_NORM: begin
        if (e_unb > UE_W'(INT_W - 1)) huge = 1'b1;
        else if (sh_s < 0)            tiny = 1'b1;
        else                          fixed = FIX_W'(sig) << sh_amt;
      end
      default: ;
    endcase
  end

  // Values below the guard weight collapse to a lone sticky bit.
  assign int_part = tiny ? '0   : fixed[FIX_W-1:FRAC_W];
  assign guard    = tiny ? 1'b0 : fixed[FRAC_W-1];
  assign sticky   = tiny ? 1'b1 : |fixed[FRAC_W-2:0];
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  rmode_e           mode,
  input  fclass_e          fclass,
  input  logic             sign,
  input  logic [INT_W-1:0] int_part,
  input  logic             guard,
  input  logic             sticky,
  input  logic             huge,
  output logic             rnd_up,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             overflow,
  output logic             inexact
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};

  logic [INT_W:0]   mag_r;
  logic             out_range;
  logic [INT_W-1:0] signed_val;

  assign rnd_up     = rnd_inc(mode, sign, int_part[0], guard, sticky);
  assign mag_r      = {1'b0, int_part} + {{INT_W{1'b0}}, rnd_up};
  assign out_range  = huge | (sign ? (mag_r > NEG_LIM) : (mag_r > POS_LIM));
  assign signed_val = sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];

  always_comb begin
    invalid  = 1'b0;
    overflow = 1'b0;
    inexact  = 1'b0;
    result   = signed_val;
    if (fclass == CL_NAN) begin
      invalid = 1'b1;
      result  = NEG_MIN;
    end else if (fclass == CL_INF || out_range) begin
      overflow = 1'b1;
      result   = sign ? NEG_MIN : POS_MAX;
    end else begin
      inexact = guard | sticky;
    end
  end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int FRAC_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic [1:0]  in_mode,
  output logic        out_valid,
  output logic [31:0] out_int,
  output logic        out_invalid,
  output logic        out_overflow,
  output logic        out_inexact
);
  localparam int WORD_W = EXP_W + MAN_W + 1;

  logic              c_sign;
  logic [EXP_W-1:0]  c_exp;
  logic [MAN_W:0]    c_sig;
  fclass_e           c_class;
  logic [INT_W-1:0]  a_int;
  logic              a_guard, a_sticky, a_huge;
  logic              r_up;
  logic [INT_W-1:0]  r_val;
  logic              r_inv, r_ovf, r_inx;
  rmode_e            mode_q;

  assign mode_q = rmode_e'(in_mode);

  f2i_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
    .word(in_word[WORD_W-1:0]), .sign(c_sign), .exp_fld(c_exp),
    .sig(c_sig), .fclass(c_class)
  );

  f2i_align #(.EW(EXP_W), .MW(MAN_W), .BIAS_V(BIAS), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_aln (
    .fclass(c_class), .exp_fld(c_exp), .sig(c_sig),
    .int_part(a_int), .guard(a_guard), .sticky(a_sticky), .huge(a_huge)
  );

  f2i_round #(.INT_W(INT_W)) u_rnd (
    .mode(mode_q), .fclass(c_class), .sign(c_sign), .int_part(a_int),
    .guard(a_guard), .sticky(a_sticky), .huge(a_huge), .rnd_up(r_up),
    .result(r_val), .invalid(r_inv), .overflow(r_ovf), .inexact(r_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_int      <= '0;
      out_invalid  <= 1'b0;
      out_overflow <= 1'b0;
      out_inexact  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int      <= r_val[31:0];
        out_invalid  <= r_inv;
        out_overflow <= r_ovf;
        out_inexact  <= r_inx;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_int) && $stable(out_inexact));
  assert_nan_code_R7: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_int == 32'h8000_0000) && !out_overflow);
  assert_sat_value_R9: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> (out_int == 32'h7FFF_FFFF) || (out_int == 32'h8000_0000));
  assert_one_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({out_invalid, out_overflow, out_inexact}) <= 1);
  assert_bump_cause_R6: assert property (@(posedge clk) disable iff (rst)
    r_up |-> (a_guard | a_sticky));
  assert_trunc_no_bump_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd1) |-> !r_up);
  assert_sub_inexact_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_class == CL_SUB) |=> out_inexact);
endmodule

// File: tb/tb_f2i_convert.sv
module tb_f2i_convert;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid, out_overflow, out_inexact;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  f2i_convert dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_mode(in_mode),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_inexact(out_inexact)
  );

  // {mode, input word, expected integer, expected {invalid, overflow, inexact}}
  localparam int NV = 37;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 32'h4020_0000, 32'h0000_0002, 3'b001}, // R4 2.5
    {2'd0, 32'h4060_0000, 32'h0000_0004, 3'b001}, // R4 3.5
    {2'd0, 32'hC020_0000, 32'hFFFF_FFFE, 3'b001}, // R4 -2.5
    {2'd0, 32'h3FC0_0000, 32'h0000_0002, 3'b001}, // R4 1.5
    {2'd0, 32'h3F00_0000, 32'h0000_0000, 3'b001}, // R4 0.5
    {2'd0, 32'hBF00_0000, 32'h0000_0000, 3'b001}, // R4 -0.5
    {2'd0, 32'h3F40_0000, 32'h0000_0001, 3'b001}, // R4 0.75
    {2'd0, 32'h42C8_0000, 32'h0000_0064, 3'b000}, // R6 100.0 exact
    {2'd0, 32'hC2C8_0000, 32'hFFFF_FF9C, 3'b000}, // R6 -100.0 exact
    {2'd0, 32'h3F80_0000, 32'h0000_0001, 3'b000}, // R6 1.0 exact
    {2'd1, 32'hBFE0_0000, 32'hFFFF_FFFF, 3'b001}, // R5 -1.75 trunc
    {2'd1, 32'h4020_0000, 32'h0000_0002, 3'b001}, // R3 2.5 trunc
    {2'd1, 32'h4060_0000, 32'h0000_0003, 3'b001}, // R5 3.5 trunc
    {2'd2, 32'h4010_0000, 32'h0000_0003, 3'b001}, // R5 2.25 up
    {2'd2, 32'hC010_0000, 32'hFFFF_FFFE, 3'b001}, // R5 -2.25 up
    {2'd2, 32'hBF40_0000, 32'h0000_0000, 3'b001}, // R5 -0.75 up
    {2'd3, 32'h3FE0_0000, 32'h0000_0001, 3'b001}, // R5 1.75 down
    {2'd3, 32'hBFE0_0000, 32'hFFFF_FFFE, 3'b001}, // R5 -1.75 down
    {2'd3, 32'hBF40_0000, 32'hFFFF_FFFF, 3'b001}, // R5 -0.75 down
    {2'd2, 32'h3580_0000, 32'h0000_0001, 3'b001}, // R6 tiny normal up
    {2'd0, 32'h0000_0001, 32'h0000_0000, 3'b001}, // R10 subnormal
    {2'd2, 32'h0000_0001, 32'h0000_0001, 3'b001}, // R10 subnormal up
    {2'd2, 32'h007F_FFFF, 32'h0000_0001, 3'b001}, // R10 largest subnormal up
    {2'd3, 32'h8000_0001, 32'hFFFF_FFFF, 3'b001}, // R10 neg subnormal down
    {2'd2, 32'h8000_0001, 32'h0000_0000, 3'b001}, // R10 neg subnormal up
    {2'd0, 32'h0000_0000, 32'h0000_0000, 3'b000}, // R11 +0
    {2'd3, 32'h8000_0000, 32'h0000_0000, 3'b000}, // R11 -0
    {2'd0, 32'h7FC0_0000, 32'h8000_0000, 3'b100}, // R7 NaN
    {2'd2, 32'hFFC0_0001, 32'h8000_0000, 3'b100}, // R7 negative NaN
    {2'd1, 32'h7F80_0001, 32'h8000_0000, 3'b100}, // R1 NaN with lowest fraction bit
    {2'd0, 32'h7F80_0000, 32'h7FFF_FFFF, 3'b010}, // R8 +inf
    {2'd1, 32'hFF80_0000, 32'h8000_0000, 3'b010}, // R8 -inf
    {2'd0, 32'h4F00_0000, 32'h7FFF_FFFF, 3'b010}, // R9 2^31
    {2'd0, 32'hCF00_0000, 32'h8000_0000, 3'b000}, // R9 -2^31 exact
    {2'd0, 32'h4EFF_FFFF, 32'h7FFF_FF80, 3'b000}, // R9 2^31-128
    {2'd0, 32'h5015_02F9, 32'h7FFF_FFFF, 3'b010}, // R9 1e10
    {2'd1, 32'hD015_02F9, 32'h8000_0000, 3'b010}  // R9 -1e10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive one operand at a falling edge; sample just after the capturing rising edge.
  task automatic apply(input logic [1:0] m, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = m;
    in_word  = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_word = '0; in_mode = '0;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    check("R2 reset valid", 32'(out_valid), 32'd0);
    check("R2 reset result", out_int, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table, back to back with in_valid held high.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][68:67], VEC[i][66:35]);
      check($sformatf("vec %0d result", i), out_int, VEC[i][34:3]);
      check($sformatf("vec %0d flags", i),
            32'({out_invalid, out_overflow, out_inexact}), 32'(VEC[i][2:0]));
      check($sformatf("vec %0d R2 valid", i), 32'(out_valid), 32'd1);
    end

    // R2: with in_valid low, valid drops and the result holds despite a new word.
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'h4060_0000;
    in_mode  = 2'd0;
    @(posedge clk); #1;
    check("R2 valid drops", 32'(out_valid), 32'd0);
    check("R2 result held", out_int, 32'h8000_0000);
    check("R2 flag held", 32'(out_overflow), 32'd1);
    @(posedge clk); #1;
    check("R2 still held", out_int, 32'h8000_0000);

    // R3: same operand under all four modes.
    apply(2'd0, 32'h3FE0_0000); check("R3 mode0 1.75", out_int, 32'd2);
    apply(2'd1, 32'h3FE0_0000); check("R3 mode1 1.75", out_int, 32'd1);
    apply(2'd2, 32'h3FE0_0000); check("R3 mode2 1.75", out_int, 32'd2);
    apply(2'd3, 32'h3FE0_0000); check("R3 mode3 1.75", out_int, 32'd1);

    // R6: inexact clears on an exact value following an inexact one.
    apply(2'd0, 32'h4120_0000);
    check("R6 exact 10.0", out_int, 32'd10);
    check("R6 exact flag", 32'(out_inexact), 32'd0);

    // R2: reset mid-stream clears valid.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R2 reset clears valid", 32'(out_valid), 32'd0);
    check("R2 reset clears result", out_int, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);

    finish_run();
  end
endmodule